// File: doc/BRIEF.md
# Falling-Edge Decade Counter with Toggle State Bits

This block is a synchronous divide-by-ten counter. Its state is four toggle-type bits that share one clock. All four bits update together on the falling edge of that clock. At each active edge a bit inverts when its toggle enable is 1 and holds when it is 0. Each enable is a minimized sum-of-products of the present state. The block does not use an adder and a compare. The count runs through the natural binary codes 0 to 9 and wraps to 0.

The count comes out as a 4-bit word with bit 3 as the most significant bit. A terminal flag marks the last state of each decade. An active-low asynchronous reset clears the state at once, whether or not the clock is running. The six codes above 9 cannot occur after reset. If one appears anyway, for example through an upset, the same toggle equations bring the state back into the legal cycle within two edges.

Top module: `decade_tff_counter`

## Requirements
- R1: While rst_ni is low, cnt_o reads 0000 and tc_o reads 0. Both take effect as soon as rst_ni falls, with no clock edge needed.
- R2: The state changes only on a falling edge of clk_i. A rising edge leaves cnt_o unchanged.
- R3: From 0000 after reset, each falling edge adds one to the count in natural binary, through 1001.
- R4: The falling edge taken in state 1001 gives 0000, so ten edges starting from 0000 return the counter to 0000.
- R5: tc_o is 1 exactly when cnt_o equals 1001. It is 0 in every other code, the unused codes 1010 to 1111 included.
- R6: Bit 0 of cnt_o inverts on every falling edge, in every state.
- R7: Bit 1 toggles when bit 3 is 0 and bit 0 is 1. Bit 2 toggles when bits 1 and 0 are both 1. Bit 3 toggles when bits 3 and 0 are both 1, or when bits 2, 1 and 0 are all 1. Every other bit holds.
- R8: The unused codes follow these paths: 1010 to 1011 to 0110, then 1100 to 1101 to 0100, then 1110 to 1111 to 0010. Each reaches a legal code within two edges and then counts normally.
- R9: A reset asserted in the middle of a count holds cnt_o at 0000 through falling edges for as long as rst_ni stays low. After release, the count resumes from 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state updates on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_o | output | 4 | Present count, bit 3 most significant |
| tc_o | output | 1 | High while the count is 1001 |

## Verification
The counter runs for several full decades after reset. Each step is compared with a modulo-ten expectation kept in the bench. This separates the toggle equations, each of which shows up at its own carry point, from a wrong wrap point at 1001. The output is sampled on both sides of the rising edge, so an update on the wrong edge is caught. Each of the six unused codes is planted in the state register and followed for three edges, and this tests the toggle terms that a legal count never reaches. A reset dropped while the count is nonzero and the clock is high separates asynchronous clearing from clearing on the next edge.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned MODULUS = 10;
  localparam int unsigned LAST_CODE = MODULUS - 1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/decade_toggle_eq.sv
module decade_toggle_eq
  import decade_pkg::*;
(
  input  cnt_t q_i,
  output cnt_t tog_o
);
  // minimized enables, valid for all 16 codes
  always_comb begin
    tog_o[0] = 1'b1;
    tog_o[1] = ~q_i[3] & q_i[0];
    tog_o[2] = q_i[1] & q_i[0];
    tog_o[3] = (q_i[3] & q_i[0]) | (q_i[2] & q_i[1] & q_i[0]);
  end
endmodule

// File: rtl/tff_bank.sv
module tff_bank #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] tog_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_q ^ tog_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/decade_tff_counter.sv
module decade_tff_counter
  import decade_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  cnt_t state_w;
  cnt_t tog_w;

  decade_toggle_eq u_eq (
    .q_i  (state_w),
    .tog_o(tog_w)
  );

  tff_bank #(.WIDTH(CNT_W)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tog_i (tog_w),
    .q_o   (state_w)
  );

  assign cnt_o = state_w;
  assign tc_o  = (state_w == cnt_t'(LAST_CODE));
endmodule

// File: rtl/decade_tff_counter_chk.sv
module decade_tff_counter_chk
  import decade_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input cnt_t cnt_i,
  input logic tc_i,
  input cnt_t tog_i
);
  cnt_t nxt_w;
  assign nxt_w = cnt_i ^ tog_i;

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_i == '0 && !tc_i));

  a_r3_step_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i < cnt_t'(LAST_CODE)) |-> (nxt_w == cnt_i + cnt_t'(1)));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |-> (nxt_w == '0));

  a_r5_no_tc_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > cnt_t'(LAST_CODE)) |-> !tc_i);

  a_r8_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > cnt_t'(LAST_CODE) && !cnt_i[0]) |-> (nxt_w == (cnt_i | cnt_t'(1))));
endmodule

bind decade_tff_counter decade_tff_counter_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cnt_i (cnt_o),
  .tc_i  (tc_o),
  .tog_i (tog_w)
);

// File: tb/tb_decade_tff_counter.sv
`timescale 1ns/1ps
module tb_decade_tff_counter;
  logic       clk_i;
  logic       rst_ni;
  logic [3:0] cnt_o;
  logic       tc_o;
  int checks;
  int errors;
  bit done;

  decade_tff_counter dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_o),
    .tc_o  (tc_o)
  );

  initial clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // plant an unused code between edges, then follow three falling edges
  task automatic plant(input logic [3:0] s, input logic [3:0] n1, input logic [3:0] n2);
    force dut.u_bank.q_q = s;
    #0.5;
    release dut.u_bank.q_q;
    #0.2;
    chk("R8 planted", cnt_o, s);
    chk("R5 unused", {3'b0, tc_o}, 4'd0);
    @(negedge clk_i); #1;
    chk("R8 first", cnt_o, n1);
    chk("R6 bit0", {3'b0, cnt_o[0]}, {3'b0, ~s[0]});
    chk("R5 unused", {3'b0, tc_o}, 4'd0);
    @(negedge clk_i); #1;
    chk("R8 second", cnt_o, n2);
    chk("R7 toggles", cnt_o ^ n1, {(n1[3] & n1[0]) | (n1[2] & n1[1] & n1[0]),
                                   n1[1] & n1[0], ~n1[3] & n1[0], 1'b1});
    @(negedge clk_i); #1;
    chk("R8 resume", cnt_o, (n2 + 4'd1) % 4'd10);
    @(posedge clk_i); #1;
  endtask

  initial begin
    logic [3:0] exp;
    logic [3:0] pre;
    int edges;
    checks = 0; errors = 0; done = 1'b0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 reset", cnt_o, 4'd0);
    chk("R1 tc", {3'b0, tc_o}, 4'd0);
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 hold", cnt_o, 4'd0);
    rst_ni = 1'b1;
    exp = 4'd0;
    edges = 0;
    for (int i = 0; i < 35; i++) begin
      @(negedge clk_i); #1;
      edges++;
      exp = (exp == 4'd9) ? 4'd0 : exp + 4'd1;
      chk(exp == 4'd0 ? "R4 wrap" : "R3 count", cnt_o, exp);
      chk("R5 tc", {3'b0, tc_o}, {3'b0, exp == 4'd9});
      chk("R6 bit0", {3'b0, cnt_o[0]}, {3'b0, edges[0]});
      if (edges % 10 == 0) chk("R4 ten", cnt_o, 4'd0);
      pre = cnt_o;
      @(posedge clk_i); #1;
      chk("R2 rise", cnt_o, pre);
    end
    // async reset mid-count, clock high
    chk("R9 nonzero", {3'b0, cnt_o != 4'd0}, 4'd1);
    rst_ni = 1'b0;
    #0.2;
    chk("R1 async", cnt_o, 4'd0);
    @(negedge clk_i); #1;
    chk("R9 held", cnt_o, 4'd0);
    @(negedge clk_i); #1;
    chk("R9 held", cnt_o, 4'd0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R9 resume", cnt_o, 4'd1);
    @(posedge clk_i); #1;
    plant(4'b1010, 4'b1011, 4'b0110);
    plant(4'b1011, 4'b0110, 4'b0111);
    plant(4'b1100, 4'b1101, 4'b0100);
    plant(4'b1101, 4'b0100, 4'b0101);
    plant(4'b1110, 4'b1111, 4'b0010);
    plant(4'b1111, 4'b0010, 4'b0011);
    summary();
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule